// File: doc/BRIEF.md
# Hash Engine Command Sequence Checker

This block sits beside a sponge-based hash engine and shadows the order of the software commands sent to it. A six-state machine follows the engine through its phases: idle, message feed, processing, absorbed and squeezing. In each phase only a small set of commands is legal. Any other command raises a sequence error, and the machine holds its state for that cycle.

When a message starts, the block also checks the configuration. It flags a mode/strength pair that the engine does not support. When the keyed mode is enabled, it also flags a function-name prefix that does not match the expected encoded value.

A life-cycle escalation input drives the machine into a terminal error state. The machine leaves that state only on an explicit clear request. Errors come out as a registered one-cycle valid with a 2-bit code. The current state is exported for the surrounding control logic.

Top module: `hash_cmd_seq_chk`

## Requirements
- R1: After reset, `state_o` is the idle code and `err_vld_o` is 0.
- R2: In idle, the command start (`cmd_i`=1) moves the machine to message feed only while `app_active_i` is 0. While `app_active_i` is 1, the machine stays idle and no error is raised.
- R3: Message feed moves to processing on the command process (2). Processing moves to absorbed only when `absorbed_i` equals exactly 4'b0110; every other value leaves it in processing.
- R4: In absorbed, the command run (3) moves to squeezing and the command done (4) moves to idle. Squeezing returns to absorbed when `keccak_done_i` is 1.
- R5: Legal commands per state: idle accepts {0,1}; message feed accepts {0,2}; absorbed accepts {0,3,4}; processing and squeezing accept {0} only. Any other value of `cmd_i` (including 5 to 7) gives error code 1 and leaves `state_o` unchanged.
- R6: On the idle-to-message-feed transition, the mode/strength pair is checked, and the state still advances. The modes are `mode_i` 0 = SHA3, 1 = SHAKE, 2 = cSHAKE and 3 = unsupported. The strengths are `strength_i` 0 = 128, 1 = 224, 2 = 256, 3 = 384, 4 = 512 and 5 to 7 unsupported. SHA3 is legal with 224, 256, 384 or 512. SHAKE and cSHAKE are legal with 128 or 256. Any other pair gives error code 2, but only while `allow_unsup_i` is 0.
- R7: On the same transition with `kmac_en_i` = 1, a `prefix_i` different from the parameter `KMAC_PREFIX` gives error code 3. With `kmac_en_i` = 0, the prefix is not checked.
- R8: Error priority is sequence (1) first, then mode/strength (2), then prefix (3). A cycle with both a mode/strength and a prefix error reports code 2.
- R9: Any `escalate_i` value other than 4'b1010 moves the machine to terminal error on the next cycle, from any state. This overrides both the command hold and the clear.
- R10: In terminal error, every command is ignored and raises no error. A `clear_i` of exactly 4'b0110, with no escalation present, returns the machine to idle from any state.
- R11: An error detected in cycle t appears on `err_vld_o`/`err_code_o` in cycle t+1 for one cycle only. `err_vld_o` is 0 in cycles with no error.
- R12: `state_o` codes are idle 6'b010110, message feed 6'b101001, processing 6'b011100, absorbed 6'b110011, squeezing 6'b000111 and terminal error 6'b111000. Any other register value is handled as terminal error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | 3 | Software command |
| mode_i | input | 2 | Hash mode |
| strength_i | input | 3 | Security strength |
| prefix_i | input | PREFIX_W | Encoded function-name prefix |
| kmac_en_i | input | 1 | Keyed mode enabled |
| allow_unsup_i | input | 1 | Suppress mode/strength error |
| app_active_i | input | 1 | Application interface owns the engine |
| absorbed_i | input | 4 | Multi-bit absorbed status |
| keccak_done_i | input | 1 | Squeeze round finished |
| escalate_i | input | 4 | Life-cycle escalation |
| clear_i | input | 4 | Multi-bit clear-after-error |
| err_vld_o | output | 1 | Error valid pulse |
| err_code_o | output | 2 | Error code |
| state_o | output | 6 | Current state code |

## Verification
A wrong internal state shows at the ports one cycle later, in two ways. `state_o` carries a different code. The legal-command set also changes, so a command that should be accepted raises error code 1, or one that should be rejected passes silently. The bench drives every command value from every reachable state and compares both the next state and the registered error against a model built from the legality table. It also sweeps every mode/strength pair, every 4-bit value of the multi-bit inputs and the prefix cases, so a mis-decoded field shows within one cycle.

// File: rtl/hseq_pkg.sv
`timescale 1ns/1ps
package hseq_pkg;
  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] CMD_NONE    = 3'd0;
  localparam logic [CMD_W-1:0] CMD_START   = 3'd1;
  localparam logic [CMD_W-1:0] CMD_PROCESS = 3'd2;
  localparam logic [CMD_W-1:0] CMD_RUN     = 3'd3;
  localparam logic [CMD_W-1:0] CMD_DONE    = 3'd4;

  localparam logic [1:0] MODE_SHA3   = 2'd0;
  localparam logic [1:0] MODE_SHAKE  = 2'd1;
  localparam logic [1:0] MODE_CSHAKE = 2'd2;

  localparam logic [2:0] STR_128 = 3'd0;
  localparam logic [2:0] STR_224 = 3'd1;
  localparam logic [2:0] STR_256 = 3'd2;
  localparam logic [2:0] STR_384 = 3'd3;
  localparam logic [2:0] STR_512 = 3'd4;

  localparam logic [3:0] MB_TRUE  = 4'b0110;
  localparam logic [3:0] ESC_OFF  = 4'b1010;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_SEQ  = 2'd1;
  localparam logic [1:0] ERR_MS   = 2'd2;
  localparam logic [1:0] ERR_PFX  = 2'd3;

  typedef enum logic [5:0] {
    ST_IDLE = 6'b010110,
    ST_FEED = 6'b101001,
    ST_PROC = 6'b011100,
    ST_ABS  = 6'b110011,
    ST_SQZ  = 6'b000111,
    ST_TERM = 6'b111000
  } state_e;
endpackage

// File: rtl/hseq_cmd_rules.sv
`timescale 1ns/1ps
module hseq_cmd_rules
  import hseq_pkg::*;
(
  input  state_e           st_i,
  input  logic [CMD_W-1:0] cmd_i,
  output logic             seq_err_o
);
  logic legal;

  always_comb begin
    case (st_i)
      ST_IDLE: legal = (cmd_i == CMD_NONE) || (cmd_i == CMD_START);
      ST_FEED: legal = (cmd_i == CMD_NONE) || (cmd_i == CMD_PROCESS);
      ST_ABS:  legal = (cmd_i == CMD_NONE) || (cmd_i == CMD_RUN) || (cmd_i == CMD_DONE);
      ST_PROC,
      ST_SQZ:  legal = (cmd_i == CMD_NONE);
      default: legal = 1'b1;  // terminal or corrupt: commands ignored
    endcase
  end

  assign seq_err_o = !legal;
endmodule

// File: rtl/hseq_cfg_check.sv
`timescale 1ns/1ps
module hseq_cfg_check
  import hseq_pkg::*;
#(
  parameter int                  PREFIX_W    = 48,
  parameter logic [PREFIX_W-1:0] KMAC_PREFIX = 48'h4341_4D4B_2001
) (
  input  logic                check_i,
  input  logic                kmac_en_i,
  input  logic                allow_unsup_i,
  input  logic [1:0]          mode_i,
  input  logic [2:0]          strength_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  output logic                ms_err_o,
  output logic                pfx_err_o
);
  logic pair_ok;

  always_comb begin
    case (mode_i)
      MODE_SHA3:  pair_ok = strength_i inside {STR_224, STR_256, STR_384, STR_512};
      MODE_SHAKE,
      MODE_CSHAKE: pair_ok = strength_i inside {STR_128, STR_256};
      default:    pair_ok = 1'b0;
    endcase
  end

  assign ms_err_o  = check_i && !pair_ok && !allow_unsup_i;
  assign pfx_err_o = check_i && kmac_en_i && (prefix_i != KMAC_PREFIX);
endmodule

// File: rtl/hseq_fsm.sv
`timescale 1ns/1ps
module hseq_fsm
  import hseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             app_active_i,
  input  logic [3:0]       absorbed_i,
  input  logic             keccak_done_i,
  input  logic [3:0]       escalate_i,
  input  logic [3:0]       clear_i,
  input  logic             seq_err_i,
  output state_e           st_o,
  output logic             start_o
);
  state_e st_q, nxt_seq, nxt;
  logic   esc, clr;

  assign esc = (escalate_i != ESC_OFF);
  assign clr = (clear_i == MB_TRUE);

  always_comb begin
    nxt_seq = st_q;
    case (st_q)
      ST_IDLE: if (!app_active_i && cmd_i == CMD_START) nxt_seq = ST_FEED;
      ST_FEED: if (cmd_i == CMD_PROCESS) nxt_seq = ST_PROC;
      ST_PROC: if (absorbed_i == MB_TRUE) nxt_seq = ST_ABS;
      ST_ABS: begin
        if (cmd_i == CMD_RUN)       nxt_seq = ST_SQZ;
        else if (cmd_i == CMD_DONE) nxt_seq = ST_IDLE;
      end
      ST_SQZ:  if (keccak_done_i) nxt_seq = ST_ABS;
      ST_TERM: nxt_seq = ST_TERM;
      default: nxt_seq = ST_TERM;
    endcase
  end

  always_comb begin
    nxt = seq_err_i ? st_q : nxt_seq;
    if (esc)      nxt = ST_TERM;
    else if (clr) nxt = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= nxt;
  end

  assign st_o    = st_q;
  assign start_o = (st_q == ST_IDLE) && (nxt == ST_FEED);

  AST_ESC_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc |=> st_q == ST_TERM); // R9
  AST_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !esc) |=> st_q == ST_IDLE); // R10
  AST_SEQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_err_i && !esc && !clr) |=> $stable(st_q)); // R5
  AST_PROC_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PROC && absorbed_i != MB_TRUE && !esc && !clr) |=> st_q == ST_PROC); // R3
  AST_APP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && app_active_i && !esc && !clr) |=> st_q == ST_IDLE); // R2
  AST_ENC_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q inside {ST_IDLE, ST_FEED, ST_PROC, ST_ABS, ST_SQZ, ST_TERM}); // R12
endmodule

// File: rtl/hash_cmd_seq_chk.sv
`timescale 1ns/1ps
module hash_cmd_seq_chk
  import hseq_pkg::*;
#(
  parameter int                  PREFIX_W    = 48,
  parameter logic [PREFIX_W-1:0] KMAC_PREFIX = 48'h4341_4D4B_2001
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2:0]          cmd_i,
  input  logic [1:0]          mode_i,
  input  logic [2:0]          strength_i,
  input  logic [PREFIX_W-1:0] prefix_i,
  input  logic                kmac_en_i,
  input  logic                allow_unsup_i,
  input  logic                app_active_i,
  input  logic [3:0]          absorbed_i,
  input  logic                keccak_done_i,
  input  logic [3:0]          escalate_i,
  input  logic [3:0]          clear_i,
  output logic                err_vld_o,
  output logic [1:0]          err_code_o,
  output logic [5:0]          state_o
);
  state_e     st;
  logic       seq_err, ms_err, pfx_err, start;
  logic [1:0] code_d;

  hseq_cmd_rules u_rules (
    .st_i      (st),
    .cmd_i     (cmd_i),
    .seq_err_o (seq_err)
  );

  hseq_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd_i),
    .app_active_i  (app_active_i),
    .absorbed_i    (absorbed_i),
    .keccak_done_i (keccak_done_i),
    .escalate_i    (escalate_i),
    .clear_i       (clear_i),
    .seq_err_i     (seq_err),
    .st_o          (st),
    .start_o       (start)
  );

  hseq_cfg_check #(
    .PREFIX_W    (PREFIX_W),
    .KMAC_PREFIX (KMAC_PREFIX)
  ) u_cfg (
    .check_i       (start),
    .kmac_en_i     (kmac_en_i),
    .allow_unsup_i (allow_unsup_i),
    .mode_i        (mode_i),
    .strength_i    (strength_i),
    .prefix_i      (prefix_i),
    .ms_err_o      (ms_err),
    .pfx_err_o     (pfx_err)
  );

  always_comb begin
    code_d = ERR_NONE;
    if (seq_err)      code_d = ERR_SEQ;
    else if (ms_err)  code_d = ERR_MS;
    else if (pfx_err) code_d = ERR_PFX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_vld_o  <= 1'b0;
      err_code_o <= ERR_NONE;
    end else begin
      err_vld_o  <= (code_d != ERR_NONE);
      err_code_o <= code_d;
    end
  end

  assign state_o = st;

  AST_PFX_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kmac_en_i |=> err_code_o != ERR_PFX); // R7
  AST_TERM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TERM) |=> !err_vld_o); // R10
  AST_MS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    allow_unsup_i |=> err_code_o != ERR_MS); // R6
endmodule

// File: tb/sim_hash_cmd_seq_chk.sv
`timescale 1ns/1ps
module sim_hash_cmd_seq_chk;
  localparam logic [5:0] S_IDLE = 6'b010110, S_FEED = 6'b101001, S_PROC = 6'b011100,
                         S_ABS  = 6'b110011, S_SQZ  = 6'b000111, S_TERM = 6'b111000;
  localparam logic [47:0] GOOD_PFX = 48'h4341_4D4B_2001;
  localparam logic [3:0] T4 = 4'b0110, F4 = 4'b1001, EOFF = 4'b1010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cmd; logic [1:0] mode; logic [2:0] str; logic [47:0] pfx;
  logic kmac_en, allow, app, done;
  logic [3:0] absd, esc, clr;
  logic err_vld; logic [1:0] err_code; logic [5:0] state;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  hash_cmd_seq_chk u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .mode_i(mode), .strength_i(str),
    .prefix_i(pfx), .kmac_en_i(kmac_en), .allow_unsup_i(allow), .app_active_i(app),
    .absorbed_i(absd), .keccak_done_i(done), .escalate_i(esc), .clear_i(clr),
    .err_vld_o(err_vld), .err_code_o(err_code), .state_o(state));

  task automatic step(); @(posedge clk); #1; endtask

  task automatic chk_st(string r, logic [5:0] exp);
    n_chk++;
    if (state !== exp) begin n_bad++; $display("FAIL %s state act=%b exp=%b", r, state, exp); end
  endtask

  task automatic chk_err(string r, logic ev, logic [1:0] ec);
    n_chk++;
    if (err_vld !== ev || (ev && err_code !== ec)) begin
      n_bad++; $display("FAIL %s err act=%b/%0d exp=%b/%0d", r, err_vld, err_code, ev, ec);
    end
  endtask

  task automatic quiet();
    cmd = 3'd0; mode = 2'd0; str = 3'd2; pfx = GOOD_PFX; kmac_en = 0; allow = 0;
    app = 0; done = 0; absd = F4; esc = EOFF; clr = F4;
  endtask

  task automatic go(logic [5:0] tgt);
    quiet(); clr = T4; step(); clr = F4;
    if (tgt == S_IDLE) return;
    cmd = 3'd1; step(); cmd = 3'd0;
    if (tgt == S_FEED) return;
    cmd = 3'd2; step(); cmd = 3'd0;
    if (tgt == S_PROC) return;
    absd = T4; step(); absd = F4;
    if (tgt == S_ABS) return;
    cmd = 3'd3; step(); cmd = 3'd0;
  endtask

  function automatic logic legal(logic [5:0] s, logic [2:0] c);
    case (s)
      S_IDLE: return c == 0 || c == 1;
      S_FEED: return c == 0 || c == 2;
      S_ABS:  return c == 0 || c == 3 || c == 4;
      default: return c == 0;
    endcase
  endfunction

  function automatic logic [5:0] nxt_of(logic [5:0] s, logic [2:0] c);
    if (s == S_IDLE && c == 1) return S_FEED;
    if (s == S_FEED && c == 2) return S_PROC;
    if (s == S_ABS && c == 3)  return S_SQZ;
    if (s == S_ABS && c == 4)  return S_IDLE;
    return s;
  endfunction

  function automatic logic pair_ok(logic [1:0] m, logic [2:0] s);
    if (m == 0) return s >= 1 && s <= 4;
    if (m == 1 || m == 2) return s == 0 || s == 2;
    return 1'b0;
  endfunction

  initial begin
    logic [5:0] sts[5] = '{S_IDLE, S_FEED, S_PROC, S_ABS, S_SQZ};
    quiet();
    #35; chk_st("R1", S_IDLE); chk_err("R1", 0, 0);
    rst_n = 1; step(); chk_st("R1", S_IDLE); chk_err("R1", 0, 0);

    // R5 / R2 / R3 / R4: every command from every working state
    foreach (sts[i]) begin
      for (int c = 0; c < 8; c++) begin
        go(sts[i]); cmd = c[2:0]; step(); cmd = 0;
        chk_st("R5", legal(sts[i], c[2:0]) ? nxt_of(sts[i], c[2:0]) : sts[i]);
        chk_err("R5", !legal(sts[i], c[2:0]), 2'd1);
      end
    end
    // R11: error lasts one cycle
    go(S_FEED); cmd = 3'd4; step(); cmd = 0; chk_err("R11", 1, 1); step(); chk_err("R11", 0, 0);

    // R2: app active blocks start, no error
    go(S_IDLE); app = 1; cmd = 3'd1; step(); chk_st("R2", S_IDLE); chk_err("R2", 0, 0); app = 0; cmd = 0;

    // R3: absorbed sweep
    for (int v = 0; v < 16; v++) begin
      go(S_PROC); absd = v[3:0]; step(); absd = F4;
      chk_st("R3", (v == 6) ? S_ABS : S_PROC);
    end
    // R4: squeeze done
    go(S_SQZ); step(); chk_st("R4", S_SQZ); done = 1; step(); done = 0; chk_st("R4", S_ABS);

    // R6: mode/strength sweep
    for (int a = 0; a < 2; a++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 8; s++) begin
          go(S_IDLE); allow = a[0]; mode = m[1:0]; str = s[2:0]; cmd = 3'd1; step(); cmd = 0;
          chk_st("R6", S_FEED);
          chk_err("R6", !pair_ok(m[1:0], s[2:0]) && a == 0, 2'd2);
        end

    // R7 / R8: prefix
    go(S_IDLE); kmac_en = 1; cmd = 1; step(); cmd = 0; chk_err("R7", 0, 0);
    go(S_IDLE); kmac_en = 1; pfx = GOOD_PFX ^ 48'h800000000000; cmd = 1; step(); cmd = 0; chk_err("R7", 1, 3);
    go(S_IDLE); kmac_en = 0; pfx = GOOD_PFX ^ 48'h1; cmd = 1; step(); cmd = 0; chk_err("R7", 0, 0);
    go(S_IDLE); kmac_en = 1; pfx = 48'h0; mode = 3; cmd = 1; step(); cmd = 0; chk_err("R8", 1, 2);
    go(S_IDLE); kmac_en = 1; pfx = 48'h0; mode = 3; allow = 1; cmd = 1; step(); cmd = 0; chk_err("R8", 1, 3);

    // R9: escalation sweep, beats clear and hold
    for (int v = 0; v < 16; v++) begin
      go(S_ABS); esc = v[3:0]; step(); esc = EOFF;
      chk_st("R9", (v == 10) ? S_ABS : S_TERM);
    end
    go(S_FEED); esc = 4'b0000; clr = T4; cmd = 3'd7; step(); chk_st("R9", S_TERM);
    esc = EOFF; clr = F4; cmd = 0;

    // R10: terminal ignores commands; clear sweep
    for (int c = 0; c < 8; c++) begin
      cmd = c[2:0]; step(); chk_st("R10", S_TERM); chk_err("R10", 0, 0);
    end
    cmd = 0; clr = T4; step(); clr = F4; chk_st("R10", S_IDLE);
    for (int v = 0; v < 16; v++) begin
      go(S_FEED); clr = v[3:0]; step(); clr = F4;
      chk_st("R10", (v == 6) ? S_IDLE : S_FEED);
    end
    // R12: codes observed
    go(S_SQZ); chk_st("R12", S_SQZ);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++; $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule